// File: doc/BRIEF.md
# Four-Lane ADC Sample Packer with Asynchronous Word FIFO

The block collects 14-bit two's complement samples from four ADC channels, one sample per ADC clock cycle on each channel that flags its sample as valid. Every sample is widened to a 16-bit slot with the sample in the upper bits and zero padding in the lowest two bits. Four samples taken one after another on the same channel are gathered into one 64-bit word, with the earliest sample in the top slot.

Each channel has its own lane. A lane writes finished words into a 16-word dual-clock FIFO. The write side runs on the ADC clock. The read side runs on a command clock that has no fixed relation to the ADC clock. The two sides exchange Gray-coded pointers through two-flop synchronisers. A downstream consumer takes words from each lane through a valid/ready pair. If a word completes while its FIFO is full, the word is discarded and a sticky overflow flag is raised for that lane.

Top module: `adcPacker`

## Requirements
- R1: Each 14-bit sample is placed in bits [15:2] of its 16-bit slot, and bits [1:0] of every slot read as zero.
- R2: The top bit of each slot equals bit 13 of the sample in it, so the sign of a negative sample is kept.
- R3: Within a 64-bit word, the first sample in time sits in [63:48], the second in [47:32], the third in [31:16] and the fourth in [15:0].
- R4: A cycle with the lane's sample-valid input low does not fill a slot and does not advance the packing position.
- R5: Each lane packs only its own channel's samples and delivers them on its own output, whatever the other lanes do.
- R6: Words cross to the command clock through a FIFO with Gray-coded pointers, leave in the order they were completed, and up to 16 words can be held per lane.
- R7: A word that completes while its lane's FIFO is full is discarded, and the words already stored are not changed.
- R8: A lane's overflow output goes high when a word is discarded and stays high until reset.
- R9: A word is removed only on a command-clock edge where valid and ready are both high; while valid is high and ready is low, the valid output and the data stay unchanged.
- R10: Reset discards any partly packed word, empties every FIFO and clears every overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adcClk | input | 1 | ADC sample clock, write side of every FIFO |
| adcRstN | input | 1 | Active-low asynchronous reset, ADC domain |
| cmdClk | input | 1 | Command clock, read side of every FIFO |
| cmdRstN | input | 1 | Active-low asynchronous reset, command domain |
| sampleValid | input | NUM_LANES | Per-lane sample strobe |
| sampleData | input | NUM_LANES*14 | Per-lane 14-bit sample; lane n uses bits [14n+13:14n] |
| outValid | output | NUM_LANES | Per-lane word available |
| outReady | input | NUM_LANES | Per-lane consumer accepts the word |
| outData | output | NUM_LANES*64 | Per-lane packed word; lane n uses bits [64n+63:64n] |
| overflow | output | NUM_LANES | Per-lane sticky word-dropped flag |

## Verification
A word is written on the ADC edge that takes its fourth sample. It appears on outValid after the write pointer passes two command-clock flops, so it shows up two to three command cycles later. Because of that uncertainty, the bench polls outValid on falling command edges, with a bounded wait, before it compares data. The overflow flag rises on the same ADC edge that drops a word. The bench reads it several ADC cycles later, and it reads the "nothing more" conditions only after a gap longer than the synchroniser latency. Every input changes on a falling edge, and every output is read on a falling edge.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;
  localparam int SLOTS      = 4;
  localparam int SLOT_W     = 16;
  localparam int SLOT_IDX_W = $clog2(SLOTS);
  localparam int WORD_W     = SLOTS * SLOT_W;

  typedef struct packed {
    logic                  load;
    logic [SLOT_IDX_W-1:0] slot;
    logic                  push;
    logic                  drop;
  } packStrobe_t;
endpackage

// File: rtl/adcPackCtrl.sv
module adcPackCtrl
  import adcpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        fifoFull,
  output packStrobe_t strobe,
  output logic        overflow
);
  logic [SLOT_IDX_W-1:0] slotCnt;
  logic                  lastSlot;

  assign lastSlot = (slotCnt == SLOT_IDX_W'(SLOTS - 1));

  always_comb begin
    strobe.load = sampleValid;
    strobe.slot = slotCnt;
    strobe.push = sampleValid && lastSlot && !fifoFull;
    strobe.drop = sampleValid && lastSlot && fifoFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt  <= '0;
      overflow <= 1'b0;
    end else begin
      if (sampleValid) slotCnt <= lastSlot ? '0 : slotCnt + 1'b1;
      if (strobe.drop) overflow <= 1'b1;
    end
  end

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_idle_holds_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(slotCnt));

  assert_drop_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |=> overflow);
endmodule

// File: rtl/adcPackData.sv
module adcPackData
  import adcpk_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  packStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [WORD_W-1:0]   word
);
  localparam int PAD_W = SLOT_W - SAMPLE_W;

  logic [SLOT_W-1:0] justified;
  logic [SLOT_W-1:0] slotReg [SLOTS-1];

  assign justified = {sampleIn, {PAD_W{1'b0}}};

  for (genvar g = 0; g < SLOTS - 1; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotReg[g] <= '0;
      else if (strobe.load && strobe.slot == SLOT_IDX_W'(g)) slotReg[g] <= justified;
    end
    assign word[(SLOTS - g) * SLOT_W - 1 -: SLOT_W] = slotReg[g];

    assert_slot_pad_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
      slotReg[g][PAD_W-1:0] == '0);
  end

  assign word[SLOT_W-1:0] = justified;

  assert_first_slot_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.slot == '0) |=>
      word[WORD_W-1 -: SAMPLE_W] == $past(sampleIn));
endmodule

// File: rtl/cdcFifo.sv
module cdcFifo #(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 4
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             full,
  input  logic             rdClk,
  input  logic             rdRstN,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [WIDTH-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext;
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext;
  logic [PTR_W-1:0] rdGraySync1, rdGraySync2;
  logic [PTR_W-1:0] wrGraySync1, wrGraySync2;
  logic             popEn;

  // write domain
  assign wrBinNext = wrBin + PTR_W'(1);
  assign full = (wrGray == {~rdGraySync2[PTR_W-1 -: 2], rdGraySync2[PTR_W-3:0]});

  always_ff @(posedge wrClk) begin
    if (wrEn) mem[wrBin[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
    end else begin
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
      if (wrEn) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
    end
  end

  // read domain
  assign rdValid   = (rdGray != wrGraySync2);
  assign popEn     = rdValid && rdReady;
  assign rdBinNext = rdBin + PTR_W'(1);
  assign rdData    = mem[rdBin[ADDR_W-1:0]];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
      if (popEn) begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
    end
  end

  assert_no_write_when_full_R7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrEn |-> !full);

  assert_wr_gray_step_R6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $onehot0(wrGray ^ $past(wrGray)));

  assert_rd_gray_step_R6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $onehot0(rdGray ^ $past(rdGray)));

  assert_hold_until_taken_R9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
endmodule

// File: rtl/adcPacker.sv
module adcPacker
  import adcpk_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int SAMPLE_W    = 14,
  parameter int FIFO_ADDR_W = 4
) (
  input  logic                          adcClk,
  input  logic                          adcRstN,
  input  logic                          cmdClk,
  input  logic                          cmdRstN,
  input  logic [NUM_LANES-1:0]          sampleValid,
  input  logic [NUM_LANES*SAMPLE_W-1:0] sampleData,
  output logic [NUM_LANES-1:0]          outValid,
  input  logic [NUM_LANES-1:0]          outReady,
  output logic [NUM_LANES*WORD_W-1:0]   outData,
  output logic [NUM_LANES-1:0]          overflow
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    packStrobe_t        strobe;
    logic [WORD_W-1:0]  packedWord;
    logic               fifoFull;

    adcPackCtrl uCtrl (
      .clk        (adcClk),
      .rstN       (adcRstN),
      .sampleValid(sampleValid[l]),
      .fifoFull   (fifoFull),
      .strobe     (strobe),
      .overflow   (overflow[l])
    );

    adcPackData #(.SAMPLE_W(SAMPLE_W)) uData (
      .clk     (adcClk),
      .rstN    (adcRstN),
      .strobe  (strobe),
      .sampleIn(sampleData[l*SAMPLE_W +: SAMPLE_W]),
      .word    (packedWord)
    );

    cdcFifo #(.WIDTH(WORD_W), .ADDR_W(FIFO_ADDR_W)) uFifo (
      .wrClk  (adcClk),
      .wrRstN (adcRstN),
      .wrEn   (strobe.push),
      .wrData (packedWord),
      .full   (fifoFull),
      .rdClk  (cmdClk),
      .rdRstN (cmdRstN),
      .rdValid(outValid[l]),
      .rdReady(outReady[l]),
      .rdData (outData[l*WORD_W +: WORD_W])
    );
  end
endmodule

// File: tb/adcPacker_test.sv
module adcPacker_test;
  localparam int NL = 4;
  localparam int SW = 14;

  logic              adcClk = 1'b0;
  logic              cmdClk = 1'b0;
  logic              rstN   = 1'b0;
  logic [NL-1:0]     sampleValid = '0;
  logic [NL*SW-1:0]  sampleData  = '0;
  logic [NL-1:0]     outValid;
  logic [NL-1:0]     outReady = '0;
  logic [NL*64-1:0]  outData;
  logic [NL-1:0]     overflow;

  int checks   = 0;
  int failures = 0;

  always #4    adcClk = ~adcClk;   // 125 MHz
  always #5.5  cmdClk = ~cmdClk;   // unrelated command clock

  adcPacker uut (
    .adcClk(adcClk), .adcRstN(rstN), .cmdClk(cmdClk), .cmdRstN(rstN),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .overflow(overflow)
  );

  typedef logic [3:0][SW-1:0] quad_t;

  function automatic logic [63:0] expWord(quad_t s);
    logic [63:0] w;
    for (int i = 0; i < 4; i++) w[63 - 16*i -: 16] = {s[i], 2'b00};
    return w;
  endfunction

  function automatic quad_t mkQuad(int base);
    quad_t q;
    for (int i = 0; i < 4; i++) q[i] = SW'(base * 37 + i * 1013 + 5);
    return q;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sampleValid = '0;
    outReady = '0;
    repeat (3) @(negedge cmdClk);
    rstN = 1'b1;
    repeat (3) @(negedge adcClk);
  endtask

  task automatic sendWord(input int lane, input quad_t s, input int gap);
    for (int i = 0; i < 4; i++) begin
      @(negedge adcClk);
      sampleValid[lane] = 1'b1;
      sampleData[lane*SW +: SW] = s[i];
      if (gap > 0) begin
        @(negedge adcClk);
        sampleValid[lane] = 1'b0;
        sampleData[lane*SW +: SW] = ~s[i];
        repeat (gap - 1) @(negedge adcClk);
      end
    end
    @(negedge adcClk);
    sampleValid[lane] = 1'b0;
  endtask

  task automatic readWord(input int lane, input logic [63:0] exp, input string tag);
    int t = 0;
    @(negedge cmdClk);
    while (!outValid[lane] && t < 400) begin
      @(negedge cmdClk);
      t++;
    end
    check(outValid[lane], {tag, " valid"}, 64'(outValid[lane]), 64'd1);
    check(outData[lane*64 +: 64] == exp, tag, outData[lane*64 +: 64], exp);
    outReady[lane] = 1'b1;
    @(negedge cmdClk);
    outReady[lane] = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(outValid == '0, "R10 reset outValid", 64'(outValid), 64'd0);
    check(overflow == '0, "R10 reset overflow", 64'(overflow), 64'd0);
  endtask

  task automatic testBasic();
    quad_t q;
    logic [63:0] w;
    q[0] = 14'h1ABC; q[1] = 14'h0123; q[2] = 14'h2FFF; q[3] = 14'h0001;
    sendWord(0, q, 0);
    readWord(0, expWord(q), "R3 slot order");
    q[0] = 14'h2000; q[1] = 14'h3FFF; q[2] = 14'h1FFF; q[3] = 14'h0000;
    sendWord(1, q, 0);
    w = outData[64 +: 64];
    readWord(1, expWord(q), "R1 justify");
    w = expWord(q);
    check(w[63] == 1'b1 && w[47] == 1'b1 && w[31] == 1'b0, "R2 sign bits",
          {61'd0, w[63], w[47], w[31]}, 64'b110);
  endtask

  task automatic testPadAndSign();
    quad_t q;
    logic [63:0] got;
    int t = 0;
    q[0] = 14'h3FFF; q[1] = 14'h2001; q[2] = 14'h1555; q[3] = 14'h2AAA;
    sendWord(2, q, 0);
    @(negedge cmdClk);
    while (!outValid[2] && t < 400) begin @(negedge cmdClk); t++; end
    got = outData[2*64 +: 64];
    check({got[49:48], got[33:32], got[17:16], got[1:0]} == 8'h00, "R1 pad bits zero",
          64'({got[49:48], got[33:32], got[17:16], got[1:0]}), 64'd0);
    check({got[63], got[47], got[31], got[15]} == 4'b1101, "R2 slot msb is sign",
          64'({got[63], got[47], got[31], got[15]}), 64'b1101);
    readWord(2, expWord(q), "R3 word lane2");
  endtask

  task automatic testGaps();
    quad_t q = mkQuad(9);
    sendWord(3, q, 3);
    readWord(3, expWord(q), "R4 idle cycles skipped");
  endtask

  task automatic testLanes();
    quad_t q [NL];
    for (int l = 0; l < NL; l++) q[l] = mkQuad(l + 40);
    for (int i = 0; i < 4; i++) begin
      @(negedge adcClk);
      for (int l = 0; l < NL; l++) begin
        sampleValid[l] = (l != 2) || (i != 1) ? 1'b1 : 1'b0;
        sampleData[l*SW +: SW] = q[l][i];
      end
    end
    @(negedge adcClk);
    sampleValid = '0;
    sampleValid[2] = 1'b1;
    sampleData[2*SW +: SW] = q[2][1];
    @(negedge adcClk);
    sampleValid = '0;
    // lane 2 got its samples in order 0,2,3,1
    for (int l = 0; l < NL; l++) begin
      quad_t e = q[l];
      if (l == 2) begin e[1] = q[2][2]; e[2] = q[2][3]; e[3] = q[2][1]; end
      readWord(l, expWord(e), "R5 lane separation");
    end
    repeat (12) @(negedge cmdClk);
    check(outValid == '0, "R5 no stray words", 64'(outValid), 64'd0);
  endtask

  task automatic testBackpressure();
    quad_t a = mkQuad(70);
    quad_t b = mkQuad(71);
    logic [63:0] first;
    int t = 0;
    sendWord(1, a, 0);
    sendWord(1, b, 0);
    @(negedge cmdClk);
    while (!outValid[1] && t < 400) begin @(negedge cmdClk); t++; end
    first = outData[64 +: 64];
    repeat (10) @(negedge cmdClk);
    check(outValid[1] && outData[64 +: 64] == first, "R9 held while not ready",
          outData[64 +: 64], first);
    readWord(1, expWord(a), "R9 first word");
    readWord(1, expWord(b), "R6 second word in order");
  endtask

  task automatic testOverflow();
    doReset();
    for (int k = 0; k < 17; k++) sendWord(0, mkQuad(100 + k), 0);
    repeat (6) @(negedge adcClk);
    check(overflow == 4'b0001, "R8 overflow raised", 64'(overflow), 64'd1);
    for (int k = 0; k < 16; k++) readWord(0, expWord(mkQuad(100 + k)), "R6 depth and order");
    repeat (15) @(negedge cmdClk);
    check(!outValid[0], "R7 dropped word absent", 64'(outValid[0]), 64'd0);
    check(overflow[0], "R8 flag sticky", 64'(overflow[0]), 64'd1);
    sendWord(0, mkQuad(200), 0);
    readWord(0, expWord(mkQuad(200)), "R7 fifo usable after drop");
    testReset();
  endtask

  task automatic testPartialReset();
    quad_t q = mkQuad(300);
    quad_t junk = mkQuad(301);
    @(negedge adcClk);
    sampleValid[0] = 1'b1; sampleData[0 +: SW] = junk[0];
    @(negedge adcClk);
    sampleData[0 +: SW] = junk[1];
    @(negedge adcClk);
    sampleValid[0] = 1'b0;
    doReset();
    sendWord(0, q, 0);
    readWord(0, expWord(q), "R10 partial word discarded");
    repeat (12) @(negedge cmdClk);
    check(!outValid[0], "R10 single word only", 64'(outValid[0]), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge adcClk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    testReset();
    testBasic();
    testPadAndSign();
    testGaps();
    testLanes();
    testBackpressure();
    testOverflow();
    testPartialReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule